// File: doc/BRIEF.md
# Card Slot Power Sequencer

This block orders the power-up and power-down of one smart-card slot. A controller raises a slot enable; the sequencer first holds the card's reset, clock and I/O pins low, then switches the slot supply on, waits for the regulator to report that the supply is stable, opens the reset and I/O channels, and finally opens the clock channel once the card clock has completed two rising edges. When the enable falls, the reset channel closes at once. The clock channel closes after two more card-clock rising edges, or at a timeout if the card clock has stopped. The I/O channel closes at the timeout, and the supply turns off only after that.

The block runs on the system clock. It takes the card clock as an asynchronous input through a synchronizer, and a one-cycle timebase pulse (nominally 1 MHz) for the timeout. A ready flag tells a channel router that the slot is fully active. Each slot has its own instance, so two slots are sequenced independently.

Top module: `card_slot_sequencer`

## Requirements
- R1: After reset, with the enable low, the supply enable, every channel enable and the ready flag are 0, and every force-low output is 1.
- R2: An enable sampled high while idle gives one cycle with all three pins forced low and the supply off. The supply enable rises on the following cycle.
- R3: With the supply on and the enable high, a supply-stable flag sampled high enables the reset and I/O channels on the next cycle, while the clock channel stays closed.
- R4: The card clock passes through SYNC_STAGES synchronizing flops and one edge flop. The clock channel opens on the cycle after the second detected card-clock rising edge that follows the opening of the I/O channel. If no such edges arrive, it stays closed.
- R5: The ready flag is 1 only when the supply and all three channels are enabled. It drops on the cycle after the enable is sampled low.
- R6: An enable sampled low while the reset channel is open closes the reset channel and forces reset low on the next cycle.
- R7: During deactivation, an open clock channel closes on the cycle after the second detected card-clock rising edge since the enable fell, or at the I/O timeout, whichever comes first.
- R8: The I/O channel closes on the cycle after the TIMEOUT_TICKS-th timebase pulse counted since deactivation began. The supply stays on for that one cycle with I/O low, and then turns off.
- R9: An enable raised again during deactivation does not cut the deactivation short. The slot returns to idle with the supply off, and activation then restarts from the all-low step.
- R10: An enable that falls during the all-low step returns the slot to idle without turning the supply on.
- R11: Each force-low output is at all times the inverse of its pin's channel enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_en | input | 1 | Slot enable; rising starts activation, falling starts deactivation |
| vcc_good | input | 1 | Regulator reports the slot supply is stable at the selected level |
| card_clk | input | 1 | Card clock, asynchronous to clk |
| tick | input | 1 | One-cycle timebase pulse for the timeout |
| vcc_on | output | 1 | Slot supply enable |
| rst_path_en | output | 1 | Reset channel enable |
| io_path_en | output | 1 | I/O channel enable |
| clk_path_en | output | 1 | Clock channel enable |
| rst_force_low | output | 1 | Force the card reset pin low |
| clk_force_low | output | 1 | Force the card clock pin low |
| io_force_low | output | 1 | Force the card I/O pin low |
| slot_ready | output | 1 | Slot fully active; for the channel router |

## Verification
The bench builds the block with its defaults: TIMEOUT_TICKS of 9, SYNC_STAGES of 2 and CLK_EDGES of 2. It drives the timebase pulse every 5 system clocks, so a whole deactivation window takes about 45 cycles. With this compressed window both deactivation cases are quick to reach: the clock channel closing on card-clock edges, and closing at the timeout when the card clock is held still. The same holds for enables dropped or raised in the middle of each sequence step.

// File: rtl/card_seq_pkg.sv
// Shared types for the card slot power sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package card_seq_pkg;

    // Sequencer phases, from idle through activation and back.
    typedef enum logic [2:0] {
        SEQ_IDLE      = 3'd0,
        SEQ_HOLD_LOW  = 3'd1,
        SEQ_POWER     = 3'd2,
        SEQ_CHAN_ON   = 3'd3,
        SEQ_ACTIVE    = 3'd4,
        SEQ_WIND_DOWN = 3'd5,
        SEQ_IO_LOW    = 3'd6
    } seq_state_t;

endpackage

// File: rtl/card_clk_rise.sv
// Brings the asynchronous card clock into the system clock domain and
// flags each rising edge for one system cycle.
// Assumes the card clock is slower than half the system clock and SYNC_STAGES >= 2.
module card_clk_rise #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic card_clk,
    output logic rise
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain plus one edge-history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], card_clk};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Rising edge seen at the end of the chain.
    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/slot_tick_timer.sv
// Counts timebase pulses while run is high and flags the pulse that
// completes LIMIT of them. Clears whenever run is low.
// Assumes tick is a one-cycle pulse in the system clock domain.
module slot_tick_timer #(
    parameter int LIMIT = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    // Tick counter, held at zero outside the counting window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    // The LIMIT-th pulse of the window.
    assign expire = run && tick && (cnt_q == W'(LIMIT - 1));

endmodule

// File: rtl/card_seq_fsm.sv
// Phase controller for one slot. It moves through hold-low, power, channel-on,
// active, wind-down and I/O-low. It also records which channels stay open
// while winding down.
// Assumes clk_rise and tmo_expire are single-cycle pulses.
module card_seq_fsm
    import card_seq_pkg::*;
#(
    parameter int CLK_EDGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_en,
    input  logic       vcc_good,
    input  logic       clk_rise,
    input  logic       tmo_expire,
    output seq_state_t state,
    output logic       io_keep,
    output logic       clk_keep,
    output logic       timer_run
);
    localparam int EW = $clog2(CLK_EDGES + 1);

    seq_state_t   state_q, state_d;
    logic [EW-1:0] edge_q;
    logic          io_keep_q, clk_keep_q;
    logic          last_edge;

    // The card-clock edge that completes the required count in this phase.
    assign last_edge = clk_rise && (edge_q == EW'(CLK_EDGES - 1));

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_IDLE:      if (slot_en) state_d = SEQ_HOLD_LOW;
            SEQ_HOLD_LOW:  state_d = slot_en ? SEQ_POWER : SEQ_IDLE;
            SEQ_POWER: begin
                if (!slot_en)     state_d = SEQ_WIND_DOWN;
                else if (vcc_good) state_d = SEQ_CHAN_ON;
            end
            SEQ_CHAN_ON: begin
                if (!slot_en)       state_d = SEQ_WIND_DOWN;
                else if (last_edge) state_d = SEQ_ACTIVE;
            end
            SEQ_ACTIVE:    if (!slot_en) state_d = SEQ_WIND_DOWN;
            SEQ_WIND_DOWN: if (tmo_expire) state_d = SEQ_IO_LOW;
            SEQ_IO_LOW:    state_d = SEQ_IDLE;
            default:       state_d = SEQ_IDLE;
        endcase
    end

    // Phase register and per-phase card-clock edge counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            edge_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                edge_q <= '0;
            end else if (clk_rise && edge_q != EW'(CLK_EDGES)) begin
                edge_q <= edge_q + EW'(1);
            end
        end
    end

    // Channels still open while winding down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_keep_q  <= 1'b0;
            clk_keep_q <= 1'b0;
        end else if (state_d != SEQ_WIND_DOWN) begin
            io_keep_q  <= 1'b0;
            clk_keep_q <= 1'b0;
        end else if (state_q != SEQ_WIND_DOWN) begin
            io_keep_q  <= (state_q == SEQ_CHAN_ON) || (state_q == SEQ_ACTIVE);
            clk_keep_q <= (state_q == SEQ_ACTIVE);
        end else if (last_edge) begin
            clk_keep_q <= 1'b0;
        end
    end

    assign state     = state_q;
    assign io_keep   = io_keep_q;
    assign clk_keep  = clk_keep_q;
    assign timer_run = (state_q == SEQ_WIND_DOWN);

endmodule

// File: rtl/card_slot_sequencer.sv
// Top of the per-slot power sequencer. It ties together the card-clock edge
// detector, the wind-down timer and the phase controller, and decodes the
// supply, channel, force-low and ready outputs.
// Assumes tick is a one-cycle pulse; card_clk may be asynchronous.
module card_slot_sequencer
    import card_seq_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 9,
    parameter int SYNC_STAGES   = 2,
    parameter int CLK_EDGES     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_en,
    input  logic vcc_good,
    input  logic card_clk,
    input  logic tick,
    output logic vcc_on,
    output logic rst_path_en,
    output logic io_path_en,
    output logic clk_path_en,
    output logic rst_force_low,
    output logic clk_force_low,
    output logic io_force_low,
    output logic slot_ready
);
    seq_state_t state;
    logic       clk_rise, tmo_expire, io_keep, clk_keep, timer_run;

    card_clk_rise #(.SYNC_STAGES(SYNC_STAGES)) u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .card_clk (card_clk),
        .rise     (clk_rise)
    );

    slot_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .tick   (tick),
        .expire (tmo_expire)
    );

    card_seq_fsm #(.CLK_EDGES(CLK_EDGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_en    (slot_en),
        .vcc_good   (vcc_good),
        .clk_rise   (clk_rise),
        .tmo_expire (tmo_expire),
        .state      (state),
        .io_keep    (io_keep),
        .clk_keep   (clk_keep),
        .timer_run  (timer_run)
    );

    // Output decode from the current phase.
    always_comb begin
        vcc_on      = (state != SEQ_IDLE) && (state != SEQ_HOLD_LOW);
        rst_path_en = (state == SEQ_CHAN_ON) || (state == SEQ_ACTIVE);
        io_path_en  = rst_path_en || ((state == SEQ_WIND_DOWN) && io_keep);
        clk_path_en = (state == SEQ_ACTIVE) || ((state == SEQ_WIND_DOWN) && clk_keep);
        slot_ready  = (state == SEQ_ACTIVE);
    end

    assign rst_force_low = ~rst_path_en;
    assign clk_force_low = ~clk_path_en;
    assign io_force_low  = ~io_path_en;

endmodule

// File: rtl/card_seq_checker.sv
// Temporal checks on the sequencer's ports, bound to every instance.
// Assumes synchronous active-low reset held for at least one edge.
module card_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic slot_en,
    input logic vcc_on,
    input logic rst_path_en,
    input logic io_path_en,
    input logic clk_path_en,
    input logic rst_force_low,
    input logic clk_force_low,
    input logic io_force_low,
    input logic slot_ready
);
    // Ready only with everything open.
    assert_ready_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        slot_ready |-> (vcc_on && rst_path_en && io_path_en && clk_path_en));

    // Supply rises only after a cycle with all pins forced low.
    assert_power_after_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_on) |-> $past(rst_force_low && clk_force_low && io_force_low));

    // Reset channel opens only with the supply already on.
    assert_rst_after_vcc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_path_en) |-> $past(vcc_on));

    // Clock channel opens only after I/O was open.
    assert_clk_after_io_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_path_en) |-> $past(io_path_en));

    // Falling enable closes reset on the next cycle.
    assert_rst_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_path_en && !slot_en) |=> !rst_path_en);

    // Supply turns off only after I/O was already low.
    assert_vcc_after_io_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vcc_on) |-> $past(!io_path_en));

    // No open channel without supply.
    assert_chan_needs_vcc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_path_en || clk_path_en || rst_path_en) |-> vcc_on);
endmodule

bind card_slot_sequencer card_seq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_en       (slot_en),
    .vcc_on        (vcc_on),
    .rst_path_en   (rst_path_en),
    .io_path_en    (io_path_en),
    .clk_path_en   (clk_path_en),
    .rst_force_low (rst_force_low),
    .clk_force_low (clk_force_low),
    .io_force_low  (io_force_low),
    .slot_ready    (slot_ready)
);

// File: tb/tb_card_slot_sequencer.sv
`timescale 1ns/1ps
module tb_card_slot_sequencer;
    localparam int LIMIT  = 9;
    localparam int SYNC   = 2;
    localparam int EDGES  = 2;
    localparam int TICK_P = 5;

    logic clk = 1'b0, rst_n = 1'b0, slot_en = 1'b0, vcc_good = 1'b0;
    logic card_clk = 1'b0, tick = 1'b0;
    logic vcc_on, rst_path_en, io_path_en, clk_path_en;
    logic rst_force_low, clk_force_low, io_force_low, slot_ready;

    int total = 0, bad = 0, cyc = 0;
    bit clk_run = 0, hold_good = 0, done = 0;

    card_slot_sequencer #(.TIMEOUT_TICKS(LIMIT), .SYNC_STAGES(SYNC), .CLK_EDGES(EDGES)) dut (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .vcc_good(vcc_good),
        .card_clk(card_clk), .tick(tick), .vcc_on(vcc_on), .rst_path_en(rst_path_en),
        .io_path_en(io_path_en), .clk_path_en(clk_path_en), .rst_force_low(rst_force_low),
        .clk_force_low(clk_force_low), .io_force_low(io_force_low), .slot_ready(slot_ready)
    );

    always #4 clk = ~clk;

    // Timebase pulse, card clock and regulator stand-in, all driven away from the edge.
    int tick_div = 0, cc_div = 0;
    logic [5:0] good_sh = '0;
    always @(negedge clk) begin
        tick_div = (tick_div == TICK_P - 1) ? 0 : tick_div + 1;
        tick <= (tick_div == 0);
        if (clk_run) begin
            cc_div = (cc_div == 2) ? 0 : cc_div + 1;
            if (cc_div == 0) card_clk <= ~card_clk;
        end
        good_sh = rst_n ? {good_sh[4:0], vcc_on} : 6'd0;
        vcc_good <= hold_good ? 1'b0 : good_sh[5];
    end

    // Behavioural reference: phase number and counters updated every edge.
    int m_mode = 0, m_e = 0, m_t = 0;
    bit m_io = 0, m_clk = 0;
    bit hist[$] = '{0, 0, 0};
    always @(posedge clk) begin
        bit rise, last, expire;
        int nx;
        if (!rst_n) begin
            m_mode = 0; m_e = 0; m_t = 0; m_io = 0; m_clk = 0;
            hist = '{0, 0, 0};
        end else begin
            rise = hist[SYNC-1] && !hist[SYNC];
            last = rise && (m_e == EDGES - 1);
            expire = (m_mode == 5) && tick && (m_t == LIMIT - 1);
            nx = m_mode;
            case (m_mode)
                0: if (slot_en) nx = 1;
                1: nx = slot_en ? 2 : 0;
                2: if (!slot_en) nx = 5; else if (vcc_good) nx = 3;
                3: if (!slot_en) nx = 5; else if (last) nx = 4;
                4: if (!slot_en) nx = 5;
                5: if (expire) nx = 6;
                default: nx = 0;
            endcase
            if (m_mode != 5) m_t = 0; else if (tick) m_t++;
            if (nx != 5) begin m_io = 0; m_clk = 0; end
            else if (m_mode != 5) begin m_io = (m_mode == 3 || m_mode == 4); m_clk = (m_mode == 4); end
            else if (last) m_clk = 0;
            if (nx != m_mode) m_e = 0; else if (rise && m_e < EDGES) m_e++;
            m_mode = nx;
            hist.push_front(card_clk);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, string what, logic act, logic exp);
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: got %b expected %b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Compare every output with the reference on every cycle.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            bit e_vcc, e_rst, e_io, e_clk;
            e_vcc = (m_mode >= 2);
            e_rst = (m_mode == 3 || m_mode == 4);
            e_io  = e_rst || (m_mode == 5 && m_io);
            e_clk = (m_mode == 4) || (m_mode == 5 && m_clk);
            total++;
            chk("R2 R8 R10", "vcc_on", vcc_on, e_vcc);
            chk("R3 R6", "rst_path_en", rst_path_en, e_rst);
            chk("R3 R8", "io_path_en", io_path_en, e_io);
            chk("R4 R7", "clk_path_en", clk_path_en, e_clk);
            chk("R5", "slot_ready", slot_ready, m_mode == 4);
            chk("R11", "rst_force_low", rst_force_low, !e_rst);
            chk("R11", "clk_force_low", clk_force_low, !e_clk);
            chk("R11", "io_force_low", io_force_low, !e_io);
        end
        if (cyc == 60000 && !done) begin
            done = 1;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic directed(string tag, string what, logic act, logic exp);
        total++;
        chk(tag, what, act, exp);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 300 && !slot_ready; i++) @(negedge clk);
    endtask

    task automatic wait_off();
        for (int i = 0; i < 300 && vcc_on; i++) @(negedge clk);
    endtask

    initial begin
        bit seen;
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1: idle state after reset.
        directed("R1", "vcc_on", vcc_on, 1'b0);
        directed("R1", "slot_ready", slot_ready, 1'b0);
        directed("R1", "rst_force_low", rst_force_low, 1'b1);
        directed("R1", "clk_force_low", clk_force_low, 1'b1);
        directed("R1", "io_force_low", io_force_low, 1'b1);

        // Normal cycle, clock running through deactivation (R7 edge path).
        clk_run = 1; slot_en = 1; wait_ready();
        directed("R5", "ready after activation", slot_ready, 1'b1);
        step(20); slot_en = 0; step(1);
        directed("R5", "ready dropped", slot_ready, 1'b0);
        wait_off();
        directed("R8", "supply off", vcc_on, 1'b0);
        step(5);

        // Clock stopped before deactivation: clock closes at timeout (R7).
        slot_en = 1; wait_ready(); clk_run = 0; step(10);
        slot_en = 0; step(20);
        directed("R7", "clock still open before timeout", clk_path_en, 1'b1);
        wait_off(); step(5);

        // R9: enable raised again mid-deactivation.
        clk_run = 1; slot_en = 1; wait_ready();
        slot_en = 0; step(8); slot_en = 1;
        wait_off();
        directed("R9", "reached idle while enable high", vcc_on, 1'b0);
        wait_ready();
        directed("R9", "restarted to active", slot_ready, 1'b1);
        slot_en = 0; wait_off(); step(5);

        // R10: enable held for a single cycle.
        slot_en = 1; step(1); slot_en = 0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin step(1); if (vcc_on) seen = 1; end
        directed("R10", "supply never on", seen, 1'b0);

        // Enable dropped while waiting for a stable supply.
        hold_good = 1; slot_en = 1; step(10); slot_en = 0;
        seen = 0;
        for (int i = 0; i < 80; i++) begin step(1); if (io_path_en) seen = 1; end
        directed("R3", "I/O never opened without stable supply", seen, 1'b0);
        hold_good = 0; step(5);

        // R4: no card-clock edges, clock channel stays closed.
        clk_run = 0; slot_en = 1; step(40);
        directed("R4", "clock closed without edges", clk_path_en, 1'b0);
        directed("R3", "I/O open", io_path_en, 1'b1);
        slot_en = 0; wait_off(); step(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule